// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside an instruction fetch stage and predicts where fetch should go next. Each cycle the fetch address is looked up in a direct-mapped table of branch records. On a hit the block reports whether the branch is expected to be taken. It also supplies the next fetch address: the recorded target for a taken prediction, otherwise the next sequential word.

When a branch resolves later in the pipeline, its program counter, real target and outcome are presented on the resolve port. A branch that hits moves its two-bit history one step toward the outcome. A branch that misses is recorded only if it was taken, and the new record begins in the strongly-not-taken state, so a newly recorded branch still predicts sequential fetch. A global enable switches the whole buffer off.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses (`hit_o` low) until an entry is allocated.
- R2: The table is indexed by PC bits [8:2], and the remaining upper bits form a tag. A lookup hits only on a valid entry whose stored tag equals the tag of the fetch PC. A PC with the same index but different upper bits misses.
- R3: A hit on an entry whose history is weakly taken (2) or strongly taken (3) drives `pred_taken_o` high and `pred_next_o` to the stored target.
- R4: A miss, or a hit on an entry whose history is strongly not-taken (0) or weakly not-taken (1), drives `pred_taken_o` low and `pred_next_o` to the fetch PC plus 4.
- R5: A taken resolve that misses writes the branch into its slot with history 0 and the given target, replacing any previous occupant. The new record is visible to lookups from the next cycle.
- R6: A not-taken resolve that misses changes no entry.
- R7: A resolve that hits moves the history one step toward taken (on taken) or toward not-taken (on not-taken), saturating at 3 and 0.
- R8: A taken resolve that hits also replaces the stored target with the resolved target.
- R9: While `en_i` is low, every lookup misses with `pred_taken_o` low and `pred_next_o` equal to PC plus 4, and resolves change no entry.
- R10: When a lookup and a resolve touch the same entry in the same cycle, the lookup reflects the entry's contents from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all valid bits |
| en_i | input | 1 | Buffer enable |
| fetch_pc_i | input | 32 | Fetch address looked up this cycle |
| hit_o | output | 1 | Lookup found a matching entry |
| pred_taken_o | output | 1 | Predicted taken |
| pred_next_o | output | 32 | Predicted next fetch address |
| res_valid_i | input | 1 | Resolve port carries a branch outcome |
| res_pc_i | input | 32 | Address of the resolved branch |
| res_target_i | input | 32 | Actual target of the resolved branch |
| res_taken_i | input | 1 | Branch was taken |

## Verification
On every cycle the assertions check that a disabled buffer never hits and that a taken prediction always comes with a hit. They also check that a not-taken prediction always points to the sequential address, and that a taken resolve with the buffer enabled makes that branch hit on the following cycle. The order of the saturating history, target refresh on a hit, slot replacement by an aliasing address, ignoring of not-taken misses, and old-contents visibility during a same-cycle update all depend on sequences of resolves. Only the bench's directed scenarios can show these behaviours.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    HIST_SNT = 2'd0,
    HIST_WNT = 2'd1,
    HIST_WT  = 2'd2,
    HIST_ST  = 2'd3
  } hist_e;

  function automatic hist_e hist_step(hist_e h, logic taken);
    hist_e n;
    n = h;
    if (taken) begin
      if (h != HIST_ST) n = hist_e'(h + 2'd1);
    end else begin
      if (h != HIST_SNT) n = hist_e'(h - 2'd1);
    end
    return n;
  endfunction

  function automatic logic hist_taken(hist_e h);
    return h[1];
  endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 7,
  parameter int ALIGN_W = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - ALIGN_W
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic unused_align;
  assign unused_align = ^pc_i[ALIGN_W-1:0];
  assign idx_o = pc_i[ALIGN_W +: IDX_W];
  assign tag_o = pc_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 23,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // lookup read port
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              lk_valid_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [ADDR_W-1:0] lk_target_o,
  output hist_e             lk_hist_o,
  // resolve read port
  input  logic [IDX_W-1:0]  rs_idx_i,
  output logic              rs_valid_o,
  output logic [TAG_W-1:0]  rs_tag_o,
  output logic [ADDR_W-1:0] rs_target_o,
  output hist_e             rs_hist_o,
  // write port
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_target_i,
  input  hist_e             wr_hist_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  target_q [ENTRIES];
  hist_e              hist_q   [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_q <= '0;
    else if (we_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // payload needs no reset: qualified by valid_q
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i]    <= wr_tag_i;
      target_q[wr_idx_i] <= wr_target_i;
      hist_q[wr_idx_i]   <= wr_hist_i;
    end
  end

  assign lk_valid_o  = valid_q[lk_idx_i];
  assign lk_tag_o    = tag_q[lk_idx_i];
  assign lk_target_o = target_q[lk_idx_i];
  assign lk_hist_o   = hist_q[lk_idx_i];

  assign rs_valid_o  = valid_q[rs_idx_i];
  assign rs_tag_o    = tag_q[rs_idx_i];
  assign rs_target_o = target_q[rs_idx_i];
  assign rs_hist_o   = hist_q[rs_idx_i];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 23,
  parameter int ALIGN_W = 2
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [TAG_W-1:0]  pc_tag_i,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [ADDR_W-1:0] ent_target_i,
  input  hist_e             ent_hist_i,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

  always_comb begin
    hit_o   = en_i && ent_valid_i && (ent_tag_i == pc_tag_i);
    taken_o = hit_o && hist_taken(ent_hist_i);
    next_o  = taken_o ? ent_target_i : pc_i + STEP;
  end
endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 23
) (
  input  logic              en_i,
  input  logic              res_valid_i,
  input  logic              res_taken_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [ADDR_W-1:0] ent_target_i,
  input  hist_e             ent_hist_i,
  output logic              we_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [ADDR_W-1:0] wr_target_o,
  output hist_e             wr_hist_o
);
  logic act, hit;

  always_comb begin
    act         = en_i && res_valid_i;
    hit         = ent_valid_i && (ent_tag_i == res_tag_i);
    we_o        = 1'b0;
    wr_tag_o    = res_tag_i;
    wr_target_o = ent_target_i;
    wr_hist_o   = ent_hist_i;
    if (act && hit) begin
      we_o      = 1'b1;
      wr_hist_o = hist_step(ent_hist_i, res_taken_i);
      if (res_taken_i) wr_target_o = res_target_i;
    end else if (act && res_taken_i) begin
      // first taken occurrence: allocate, start strongly not-taken
      we_o        = 1'b1;
      wr_target_o = res_target_i;
      wr_hist_o   = HIST_SNT;
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] pred_next_o,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              res_taken_i
);
  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [TAG_W-1:0]  lk_pc_tag, rs_pc_tag;
  logic              lk_valid, rs_valid, we;
  logic [TAG_W-1:0]  lk_tag, rs_tag, wr_tag;
  logic [ADDR_W-1:0] lk_target, rs_target, wr_target;
  hist_e             lk_hist, rs_hist, wr_hist;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_lk (
    .pc_i(fetch_pc_i), .idx_o(lk_idx), .tag_o(lk_pc_tag)
  );

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_split_rs (
    .pc_i(res_pc_i), .idx_o(rs_idx), .tag_o(rs_pc_tag)
  );

  btb_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (lk_idx),
    .lk_valid_o  (lk_valid),
    .lk_tag_o    (lk_tag),
    .lk_target_o (lk_target),
    .lk_hist_o   (lk_hist),
    .rs_idx_i    (rs_idx),
    .rs_valid_o  (rs_valid),
    .rs_tag_o    (rs_tag),
    .rs_target_o (rs_target),
    .rs_hist_o   (rs_hist),
    .we_i        (we),
    .wr_idx_i    (rs_idx),
    .wr_tag_i    (wr_tag),
    .wr_target_i (wr_target),
    .wr_hist_i   (wr_hist)
  );

  btb_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .ALIGN_W(ALIGN_W)) u_lookup (
    .en_i         (en_i),
    .pc_i         (fetch_pc_i),
    .pc_tag_i     (lk_pc_tag),
    .ent_valid_i  (lk_valid),
    .ent_tag_i    (lk_tag),
    .ent_target_i (lk_target),
    .ent_hist_i   (lk_hist),
    .hit_o        (hit_o),
    .taken_o      (pred_taken_o),
    .next_o       (pred_next_o)
  );

  btb_update #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_update (
    .en_i         (en_i),
    .res_valid_i  (res_valid_i),
    .res_taken_i  (res_taken_i),
    .res_tag_i    (rs_pc_tag),
    .res_target_i (res_target_i),
    .ent_valid_i  (rs_valid),
    .ent_tag_i    (rs_tag),
    .ent_target_i (rs_target),
    .ent_hist_i   (rs_hist),
    .we_o         (we),
    .wr_tag_o     (wr_tag),
    .wr_target_o  (wr_target),
    .wr_hist_o    (wr_hist)
  );
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [ADDR_W-1:0] fetch_pc_i,
  input logic              hit_o,
  input logic              pred_taken_o,
  input logic [ADDR_W-1:0] pred_next_o,
  input logic              res_valid_i,
  input logic [ADDR_W-1:0] res_pc_i,
  input logic              res_taken_i
);
  // R9
  disabled_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!hit_o && !pred_taken_o));

  // R3
  taken_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> hit_o);

  // R4
  seq_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> (pred_next_o == fetch_pc_i + ADDR_W'(4)));

  // R5
  alloc_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && res_valid_i && res_taken_i) |=>
      (!en_i || fetch_pc_i != $past(res_pc_i) || hit_o));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .fetch_pc_i   (fetch_pc_i),
  .hit_o        (hit_o),
  .pred_taken_o (pred_taken_o),
  .pred_next_o  (pred_next_o),
  .res_valid_i  (res_valid_i),
  .res_pc_i     (res_pc_i),
  .res_taken_i  (res_taken_i)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int AW = 32;
  localparam logic [AW-1:0] PC_A = 32'h0000_1004;
  localparam logic [AW-1:0] PC_C = 32'h0000_1204; // same index as PC_A, other tag
  localparam logic [AW-1:0] PC_B = 32'h0000_4008;
  localparam logic [AW-1:0] T1   = 32'h0000_2000;
  localparam logic [AW-1:0] T2   = 32'h0000_3000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic [AW-1:0] fetch_pc = '0;
  logic          hit, ptaken;
  logic [AW-1:0] pnext;
  logic          res_valid = 1'b0;
  logic [AW-1:0] res_pc = '0;
  logic [AW-1:0] res_target = '0;
  logic          res_taken = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  btb_predictor dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fetch_pc_i(fetch_pc),
    .hit_o(hit), .pred_taken_o(ptaken), .pred_next_o(pnext),
    .res_valid_i(res_valid), .res_pc_i(res_pc),
    .res_target_i(res_target), .res_taken_i(res_taken)
  );

  task automatic check(string req, logic [AW-1:0] pc, logic eh, logic et, logic [AW-1:0] en_);
    total++;
    if (hit !== eh || ptaken !== et || pnext !== en_) begin
      bad++;
      $display("FAIL %s pc=%h: got hit=%b taken=%b next=%h exp hit=%b taken=%b next=%h",
               req, pc, hit, ptaken, pnext, eh, et, en_);
    end
  endtask

  task automatic lookup(string req, logic [AW-1:0] pc, logic eh, logic et, logic [AW-1:0] en_);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(req, pc, eh, et, en_);
  endtask

  task automatic resolve(logic [AW-1:0] pc, logic [AW-1:0] tgt, logic tk);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_target = tgt; res_taken = tk;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    lookup("R1", PC_A, 0, 0, PC_A + 4);
    lookup("R1", PC_C, 0, 0, PC_C + 4);
  endtask

  task automatic t_nt_miss;
    resolve(PC_A, T1, 0);
    lookup("R6", PC_A, 0, 0, PC_A + 4);
  endtask

  task automatic t_alloc;
    resolve(PC_A, T1, 1);
    lookup("R5_alloc_snt", PC_A, 1, 0, PC_A + 4);
  endtask

  task automatic t_counter;
    resolve(PC_A, T1, 1); // WNT
    lookup("R7_wnt", PC_A, 1, 0, PC_A + 4);
    resolve(PC_A, T1, 1); // WT
    lookup("R3_wt", PC_A, 1, 1, T1);
    resolve(PC_A, T1, 1); // ST
    lookup("R3_st", PC_A, 1, 1, T1);
    resolve(PC_A, T1, 1); // stays ST
    resolve(PC_A, T1, 0); // WT
    lookup("R7_sat_hi", PC_A, 1, 1, T1);
    resolve(PC_A, T1, 0); // WNT
    lookup("R7_down", PC_A, 1, 0, PC_A + 4);
    resolve(PC_A, T1, 0); // SNT
    resolve(PC_A, T1, 0); // stays SNT
    resolve(PC_A, T1, 1); // WNT
    lookup("R7_sat_lo", PC_A, 1, 0, PC_A + 4);
    resolve(PC_A, T1, 1); // WT
    lookup("R7_up", PC_A, 1, 1, T1);
  endtask

  task automatic t_target;
    resolve(PC_A, T2, 1); // ST, new target
    lookup("R8", PC_A, 1, 1, T2);
  endtask

  task automatic t_alias;
    lookup("R2_alias_miss", PC_C, 0, 0, PC_C + 4);
    resolve(PC_C, T1, 1);
    lookup("R5_replace", PC_C, 1, 0, PC_C + 4);
    lookup("R5_evicted", PC_A, 0, 0, PC_A + 4);
  endtask

  task automatic t_same_cycle;
    resolve(PC_C, T1, 1); // WNT
    resolve(PC_C, T1, 1); // WT
    @(negedge clk);
    fetch_pc = PC_C;
    res_valid = 1'b1; res_pc = PC_C; res_target = T2; res_taken = 1'b0;
    #1;
    check("R10_old", PC_C, 1, 1, T1);
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    check("R10_after", PC_C, 1, 0, PC_C + 4);
  endtask

  task automatic t_disable;
    @(negedge clk);
    en = 1'b0;
    lookup("R9_lookup", PC_C, 0, 0, PC_C + 4);
    resolve(PC_B, T1, 1);
    resolve(PC_C, T1, 1);
    @(negedge clk);
    en = 1'b1;
    lookup("R9_no_alloc", PC_B, 0, 0, PC_B + 4);
    lookup("R9_no_update", PC_C, 1, 0, PC_C + 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nt_miss();
    t_alloc();
    t_counter();
    t_target();
    t_alias();
    t_same_cycle();
    t_disable();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule